// File: doc/BRIEF.md
# Rotating Priority Resolver With End-of-Interrupt Handling

This block picks, among eight interrupt levels, the highest-priority one that may be delivered to the processor now. It keeps two pieces of state: an in-service vector, which records levels whose handlers are running, and a lowest-priority pointer. Priority runs from the level just after the pointer, wrapping round, down to the pointer itself. A level wins when it is requested and unmasked and no in-service level of equal or higher priority blocks it. Two mode flags change the blocking rule. Special mask mode removes in-service blocking entirely. Nested-cascade mode, on the master instance only, lets level 2 (the cascade input) stay open while it is in service.

The surrounding controller feeds in the raw request and mask vectors and the mode flags. It sends commands through a command strobe with a 3-bit level field. End-of-interrupt commands clear an in-service bit: either the one named by the level field or the highest-priority one that is set. When rotation is enabled, an end-of-interrupt also moves the pointer. A set-priority command loads the pointer directly. When the processor acknowledges a level, that level is either marked in service or, in automatic end-of-interrupt mode, only used to rotate the pointer. The winner output is combinational from the registered state and the current inputs.

Top module: `rot_prio_resolver`

## Requirements
- R1: After reset `inService` is all zeros and the pointer is 7, so level 0 has the highest priority and level 7 the lowest.
- R2: With pointer P, levels are ranked P+1, P+2, … wrapping modulo 8, with P ranked last. `winLevel` is the first level in that order whose `reqVec` bit is 1 and `maskVec` bit is 0, and `winValid` is 1 exactly when such a level exists and is not blocked (R3).
- R3: Outside special mask mode, the scan stops with `winValid`=0 at the first level in priority order whose in-service bit is 1, so a request can win only above every in-service level.
- R4: With `nestedMode`=1 on the master instance (`IS_MASTER`=1), in-service bit 2 does not block; every other in-service bit still blocks.
- R5: With `specialMask`=1, in-service bits never block; only `maskVec` excludes levels.
- R6: A non-specific end-of-interrupt (`cmdStrobe`=1, `cmdEoi`=1, `cmdSpecific`=0) clears the highest-priority set in-service bit. With `specialMask`=1 it passes over in-service bits whose `maskVec` bit is 1. If no bit qualifies, nothing changes.
- R7: A specific end-of-interrupt (`cmdStrobe`=1, `cmdEoi`=1, `cmdSpecific`=1) clears in-service bit `cmdLevel`.
- R8: When `rotateEn`=1 and an end-of-interrupt selects a level, the pointer becomes that level. When `rotateEn`=0 the pointer does not move.
- R9: A set-priority command (`cmdStrobe`=1, `cmdEoi`=0, `cmdSpecific`=1) with `rotateEn`=1 loads the pointer from `cmdLevel`. With `rotateEn`=0, or with `cmdSpecific`=0, the command has no effect.
- R10: An acknowledge (`ackStrobe`=1) with `autoEoi`=0 sets in-service bit `ackLevel` at the next clock edge.
- R11: An acknowledge with `autoEoi`=1 leaves `inService` unchanged. If `rotateEn`=1 the pointer moves to `ackLevel`.
- R12: When `ackStrobe` and `cmdStrobe` are both 1 in the same cycle, only the acknowledge takes effect and the command is discarded.
- R13: `winValid` and `winLevel` follow changes of `reqVec`, `maskVec` and the mode flags within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqVec | input | 8 | Request per level |
| maskVec | input | 8 | Mask per level, 1 excludes the level |
| specialMask | input | 1 | Special mask mode |
| nestedMode | input | 1 | Nested-cascade mode (master instance only) |
| autoEoi | input | 1 | Automatic end-of-interrupt on acknowledge |
| rotateEn | input | 1 | Rotation enable for end-of-interrupt and acknowledge |
| cmdStrobe | input | 1 | Command valid for one cycle |
| cmdEoi | input | 1 | Command is an end-of-interrupt |
| cmdSpecific | input | 1 | Command uses `cmdLevel` |
| cmdLevel | input | 3 | Level field of the command |
| ackStrobe | input | 1 | Processor acknowledge for one cycle |
| ackLevel | input | 3 | Acknowledged level |
| winValid | output | 1 | A deliverable level exists |
| winLevel | output | 3 | Winning level, meaningful when `winValid`=1 |
| inService | output | 8 | In-service vector |

## Verification
The assertions take for granted that the strobes and their level fields are stable over the whole clock period. They also take for granted that the mode flags seen at a clock edge are the ones that govern that edge's update. The bench therefore changes every input only on the falling edge and holds it through the next rising edge. Nothing constrains the relation between an acknowledged level and the current winner. The random phase mostly acknowledges the winner but sometimes an arbitrary level, and the properties on `inService` hold either way. The blocking property is only claimed outside both special modes, which the bench also toggles.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Where the level used by a state update comes from
  typedef enum logic [1:0] {
    SRC_ACK  = 2'd0,
    SRC_CMD  = 2'd1,
    SRC_SCAN = 2'd2
  } lvlSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    setBit;   // set in-service bit of the selected level
    logic    clrBit;   // clear in-service bit of the selected level
    logic    loadPtr;  // load lowest-priority pointer with the selected level
    lvlSrc_e src;
  } arbCtl_t;

endpackage

// File: rtl/prio_scan.sv
// Walks the levels from basePtr+1 round to basePtr, stopping at the first
// stop bit or returning the first candidate bit found.
module prio_scan #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  candVec,
  input  logic [N-1:0]  stopVec,
  input  logic [LW-1:0] basePtr,
  output logic          hit,
  output logic [LW-1:0] lvl
);

  logic          done;
  logic [LW-1:0] idx;

  always_comb begin
    hit  = 1'b0;
    lvl  = '0;
    done = 1'b0;
    idx  = '0;
    for (int i = 0; i < N; i++) begin
      idx = basePtr + LW'(i) + LW'(1);
      if (!done) begin
        if (stopVec[idx]) begin
          done = 1'b1;
        end else if (candVec[idx]) begin
          hit  = 1'b1;
          lvl  = idx;
          done = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/arb_ctrl.sv
// Decodes acknowledge and command strobes into datapath update strobes.
module arb_ctrl
  import arb_pkg::*;
(
  input  logic    ackStrobe,
  input  logic    autoEoi,
  input  logic    rotateEn,
  input  logic    cmdStrobe,
  input  logic    cmdEoi,
  input  logic    cmdSpecific,
  input  logic    nsHit,
  output arbCtl_t ctl
);

  logic eoiHit;

  always_comb begin
    ctl    = '{setBit: 1'b0, clrBit: 1'b0, loadPtr: 1'b0, src: SRC_ACK};
    eoiHit = cmdSpecific | nsHit;
    if (ackStrobe) begin
      // acknowledge outranks any command in the same cycle
      ctl.src     = SRC_ACK;
      ctl.setBit  = !autoEoi;
      ctl.loadPtr = autoEoi && rotateEn;
    end else if (cmdStrobe && cmdEoi) begin
      ctl.src     = cmdSpecific ? SRC_CMD : SRC_SCAN;
      ctl.clrBit  = eoiHit;
      ctl.loadPtr = eoiHit && rotateEn;
    end else if (cmdStrobe && cmdSpecific && rotateEn) begin
      ctl.src     = SRC_CMD;
      ctl.loadPtr = 1'b1;
    end
  end

endmodule

// File: rtl/arb_datapath.sv
// In-service register, pointer register and the two priority scans.
module arb_datapath
  import arb_pkg::*;
#(
  parameter int N         = 8,
  parameter int LW        = $clog2(N),
  parameter bit IS_MASTER = 1'b1,
  parameter int CASC_LVL  = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  arbCtl_t       ctl,
  input  logic [LW-1:0] ackLevel,
  input  logic [LW-1:0] cmdLevel,
  input  logic [N-1:0]  reqVec,
  input  logic [N-1:0]  maskVec,
  input  logic          specialMask,
  input  logic          nestedMode,
  output logic          winValid,
  output logic [LW-1:0] winLevel,
  output logic [N-1:0]  isrVec,
  output logic          nsHit
);

  localparam logic [LW-1:0] PTR_RESET = LW'(N - 1);
  localparam logic [N-1:0]  CASC_BIT  = N'(1) << CASC_LVL;

  logic [N-1:0]  isrQ;
  logic [LW-1:0] lowPtrQ;
  logic [N-1:0]  blockVec;
  logic [N-1:0]  eoiCand;
  logic [LW-1:0] nsLevel;
  logic [LW-1:0] selLevel;

  generate
    if (IS_MASTER) begin : g_master
      always_comb begin
        if (specialMask)      blockVec = '0;
        else if (nestedMode)  blockVec = isrQ & ~CASC_BIT;
        else                  blockVec = isrQ;
      end
    end else begin : g_slave
      logic unusedNested;
      assign unusedNested = nestedMode;
      always_comb blockVec = specialMask ? '0 : isrQ;
    end
  endgenerate

  assign eoiCand = isrQ & ~(specialMask ? maskVec : '0);

  prio_scan #(.N(N), .LW(LW)) u_winScan (
    .candVec (reqVec & ~maskVec),
    .stopVec (blockVec),
    .basePtr (lowPtrQ),
    .hit     (winValid),
    .lvl     (winLevel)
  );

  prio_scan #(.N(N), .LW(LW)) u_eoiScan (
    .candVec (eoiCand),
    .stopVec ('0),
    .basePtr (lowPtrQ),
    .hit     (nsHit),
    .lvl     (nsLevel)
  );

  always_comb begin
    case (ctl.src)
      SRC_ACK:  selLevel = ackLevel;
      SRC_CMD:  selLevel = cmdLevel;
      default:  selLevel = nsLevel;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrQ    <= '0;
      lowPtrQ <= PTR_RESET;
    end else begin
      if (ctl.setBit)       isrQ <= isrQ | (N'(1) << selLevel);
      else if (ctl.clrBit)  isrQ <= isrQ & ~(N'(1) << selLevel);
      if (ctl.loadPtr)      lowPtrQ <= selLevel;
    end
  end

  assign isrVec = isrQ;

endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import arb_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter bit IS_MASTER  = 1'b1,
  parameter int CASC_LVL   = 2,
  localparam int LW        = $clog2(NUM_LEVELS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqVec,
  input  logic [NUM_LEVELS-1:0] maskVec,
  input  logic                  specialMask,
  input  logic                  nestedMode,
  input  logic                  autoEoi,
  input  logic                  rotateEn,
  input  logic                  cmdStrobe,
  input  logic                  cmdEoi,
  input  logic                  cmdSpecific,
  input  logic [LW-1:0]         cmdLevel,
  input  logic                  ackStrobe,
  input  logic [LW-1:0]         ackLevel,
  output logic                  winValid,
  output logic [LW-1:0]         winLevel,
  output logic [NUM_LEVELS-1:0] inService
);

  arbCtl_t ctl;
  logic    nsHit;

  arb_ctrl u_ctrl (
    .ackStrobe   (ackStrobe),
    .autoEoi     (autoEoi),
    .rotateEn    (rotateEn),
    .cmdStrobe   (cmdStrobe),
    .cmdEoi      (cmdEoi),
    .cmdSpecific (cmdSpecific),
    .nsHit       (nsHit),
    .ctl         (ctl)
  );

  arb_datapath #(
    .N(NUM_LEVELS), .LW(LW), .IS_MASTER(IS_MASTER), .CASC_LVL(CASC_LVL)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .ackLevel    (ackLevel),
    .cmdLevel    (cmdLevel),
    .reqVec      (reqVec),
    .maskVec     (maskVec),
    .specialMask (specialMask),
    .nestedMode  (nestedMode),
    .winValid    (winValid),
    .winLevel    (winLevel),
    .isrVec      (inService),
    .nsHit       (nsHit)
  );

endmodule

// File: rtl/rot_prio_resolver_chk.sv
module rot_prio_resolver_chk #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input logic          clk,
  input logic          rstN,
  input logic [N-1:0]  reqVec,
  input logic [N-1:0]  maskVec,
  input logic          specialMask,
  input logic          nestedMode,
  input logic          autoEoi,
  input logic          cmdStrobe,
  input logic          cmdEoi,
  input logic          cmdSpecific,
  input logic [LW-1:0] cmdLevel,
  input logic          ackStrobe,
  input logic [LW-1:0] ackLevel,
  input logic          winValid,
  input logic [LW-1:0] winLevel,
  input logic [N-1:0]  inService
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> inService == '0);

  p_win_eligible_r2: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (reqVec[winLevel] && !maskVec[winLevel]));

  p_isr_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && !specialMask && !nestedMode) |-> !inService[winLevel]);

  p_spec_eoi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStrobe && cmdEoi && cmdSpecific && !ackStrobe) |=> !inService[$past(cmdLevel)]);

  // R10, and R12 when a command shares the cycle
  p_ack_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !autoEoi) |=> inService[$past(ackLevel)]);

  p_aeoi_keeps_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && autoEoi) |=> $stable(inService));

  // in-service state moves only on a strobe (R10, R7)
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ackStrobe && !cmdStrobe) |=> $stable(inService));

endmodule

bind rot_prio_resolver rot_prio_resolver_chk #(.N(NUM_LEVELS)) u_chk (.*);

// File: tb/rot_prio_resolver_test.sv
`timescale 1ns/1ps
module rot_prio_resolver_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] reqVec = '0, maskVec = '0;
  logic       specialMask = 0, nestedMode = 0, autoEoi = 0, rotateEn = 0;
  logic       cmdStrobe = 0, cmdEoi = 0, cmdSpecific = 0, ackStrobe = 0;
  logic [2:0] cmdLevel = '0, ackLevel = '0;
  logic       winValid;
  logic [2:0] winLevel;
  logic [7:0] inService;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  // reference state
  bit [7:0] mIsr;
  int       mLow;

  always #10 clk = ~clk;

  rot_prio_resolver uut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  function automatic void modelWin(output bit v, output int l);
    bit [7:0] blk;
    v = 0; l = 0;
    blk = specialMask ? 8'h00 : (nestedMode ? (mIsr & 8'hFB) : mIsr);
    for (int i = 0; i < 8; i++) begin
      int p = (mLow + 1 + i) % 8;
      if (blk[p]) return;
      if (reqVec[p] && !maskVec[p]) begin v = 1; l = p; return; end
    end
  endfunction

  function automatic void modelStep();
    if (ackStrobe) begin
      if (autoEoi) begin
        if (rotateEn) mLow = ackLevel;
      end else mIsr[ackLevel] = 1'b1;
    end else if (cmdStrobe && cmdEoi) begin
      int t = -1;
      if (cmdSpecific) t = cmdLevel;
      else
        for (int i = 0; i < 8; i++) begin
          int p = (mLow + 1 + i) % 8;
          if (t < 0 && mIsr[p] && !(specialMask && maskVec[p])) t = p;
        end
      if (t >= 0) begin
        mIsr[t] = 1'b0;
        if (rotateEn) mLow = t;
      end
    end else if (cmdStrobe && cmdSpecific && rotateEn) mLow = cmdLevel;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // called just after a falling edge with inputs set up
  task automatic tick(input string tag);
    bit v; int l;
    #1;
    modelWin(v, l);
    check({tag, " winValid"}, winValid, v);
    if (v) check({tag, " winLevel"}, winLevel, l);
    check({tag, " inService"}, inService, mIsr);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    cmdStrobe = 0; cmdEoi = 0; cmdSpecific = 0; ackStrobe = 0;
  endtask

  task automatic ack(input int lvl);
    ackStrobe = 1; ackLevel = 3'(lvl);
  endtask

  task automatic cmd(input bit eoi, input bit spec, input int lvl);
    cmdStrobe = 1; cmdEoi = eoi; cmdSpecific = spec; cmdLevel = 3'(lvl);
  endtask

  initial begin
    mIsr = '0; mLow = 7;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset inService", inService, 0);
    rstN = 1;
    @(negedge clk);
    reqVec = 8'hFF;               tick("R1 level0 first");
    check("R1 level0 winLevel", winLevel, 0);
    reqVec = 8'h90;               tick("R2 lowest set");
    reqVec = 8'h90; maskVec = 8'h10; tick("R2 mask excludes");
    maskVec = 0; ack(4);          tick("R10 ack sets");
    reqVec = 8'h81;               tick("R3 higher passes");
    reqVec = 8'h80;               tick("R3 blocked below");
    specialMask = 1;              tick("R5 no blocking");
    maskVec = 8'h80;              tick("R5 mask still excludes");
    specialMask = 0; maskVec = 0; cmd(1, 0, 0); tick("R6 ns eoi");
    ack(2);                       tick("R10 ack level 2");
    reqVec = 8'h08;               tick("R4 blocked by 2");
    nestedMode = 1;               tick("R4 cascade open");
    nestedMode = 0; cmd(1, 1, 2); tick("R7 spec eoi");
    tick("R7 after clear");
    ack(0);                       tick("R10 ack 0");
    ack(3);                       tick("R10 ack 3");
    specialMask = 1; maskVec = 8'h01; cmd(1, 0, 0); tick("R6 smm skips masked");
    tick("R6 result");
    specialMask = 0; maskVec = 0; cmd(1, 0, 0); tick("R6 clear rest");
    cmd(1, 0, 0);                 tick("R6 nothing left");
    ack(5);                       tick("R10 ack 5");
    rotateEn = 1; cmd(1, 0, 0);   tick("R8 rotate eoi");
    reqVec = 8'h41;               tick("R8 after rotate");
    reqVec = 8'h21;               tick("R8 lowest last");
    cmd(0, 1, 1);                 tick("R9 set prio");
    reqVec = 8'h06;               tick("R9 new order");
    rotateEn = 0; cmd(0, 1, 6);   tick("R9 no rotate ignored");
    cmd(0, 0, 6); rotateEn = 1;   tick("R9 no specific ignored");
    rotateEn = 1; autoEoi = 1; ack(3); tick("R11 aeoi ack");
    reqVec = 8'h18;               tick("R11 pointer moved");
    autoEoi = 0; ack(0); cmd(1, 1, 0); tick("R12 ack beats cmd");
    reqVec = 8'h00; tick("R12 result");
    ack(6); cmd(0, 1, 2); tick("R12 ack beats set prio");
    reqVec = 8'hFF; maskVec = 8'h00; #3; check("R13 comb follow valid", winValid, 1);
    tick("R13 comb follow");
    cmd(1, 0, 0); tick("R6 drain");
    cmd(1, 0, 0); tick("R6 drain");
    rotateEn = 0;

    for (int n = 0; n < 4000; n++) begin
      bit v; int l;
      reqVec  = 8'($urandom);
      maskVec = 8'($urandom) & 8'($urandom);
      if ($urandom_range(0, 15) == 0) specialMask = ~specialMask;
      if ($urandom_range(0, 15) == 0) nestedMode = ~nestedMode;
      if ($urandom_range(0, 15) == 0) autoEoi = ~autoEoi;
      if ($urandom_range(0, 7) == 0) rotateEn = ~rotateEn;
      modelWin(v, l);
      if ($urandom_range(0, 2) == 0) ack(v ? l : int'($urandom_range(0, 7)));
      if ($urandom_range(0, 3) == 0)
        cmd(1'($urandom), 1'($urandom), int'($urandom_range(0, 7)));
      tick("R2 R3 R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule